// File: doc/BRIEF.md
# Packed Signed Multiply-Accumulate Unit

This unit sits beside a processor pipeline as a coprocessor and keeps one private 40-bit signed accumulator. Each issued instruction word comes with two 32-bit register operands. The unit decodes the word into one of three signed multiply-accumulate forms:

- a full 32x32 product;
- two 16x16 products, one from the upper halves and one from the lower halves;
- one 16x16 product whose operand halves are picked by instruction bits.

It adds the result into the accumulator. A word that does not match a legal pattern raises an undefined-instruction pulse and leaves the accumulator as it was.

The issue port follows valid/ready rules. Ready is high in every cycle outside reset, so an instruction is taken in any cycle where valid is high. The accumulator can be read on a port and cleared with a synchronous clear input. Reading and writing the register file, evaluating conditions and moving data between the accumulator and core registers are handled elsewhere.

Top module: `pmac_unit`

## Requirements
- R1: Instruction bits [19:18] pick the operation. 2'b00 is the full-word MAC, 2'b10 is the dual-halfword MAC, 2'b11 is the selectable-halfword MAC, and 2'b01 is undefined.
- R2: A word is legal only when bits [11:4] equal 8'h01. Any other value there makes the word undefined.
- R3: The full-word and dual-halfword forms also need bits [17:16] = 2'b00, or the word is undefined. The selectable-halfword form accepts any value in bits [17:16].
- R4: The full-word form adds the signed 64-bit product of opa and opb to the accumulator. Bits above 39 are dropped, and the sum wraps modulo 2^40 with no saturation.
- R5: The dual-halfword form adds signed(opa[31:16])*signed(opb[31:16]) plus signed(opa[15:0])*signed(opb[15:0]). Each product is sign-extended from 32 bits.
- R6: In the selectable-halfword form, bit 17 picks opa[31:16] when 1 and opa[15:0] when 0. Bit 16 picks the half of opb in the same way. The signed product is sign-extended from 32 bits and added.
- R7: An issued undefined word sets undef_out high for exactly the one cycle after the issue edge and does not change acc_out.
- R8: A legal issue updates the accumulator at the issue clock edge, and the new value is on acc_out in the following cycle. Issues in back-to-back cycles each accumulate.
- R9: When acc_clear is high at an edge, acc_out becomes 0 in the following cycle. This overrides a legal operation issued in the same cycle.
- R10: After reset, acc_out is 0, undef_out is 0 and issue_ready is 0 while reset is held.
- R11: With issue_valid low, acc_out and undef_out do not change. Instruction bits [31:20], [15:12] and [3:0] have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Unit can take an instruction (high outside reset) |
| instr | input | 32 | Instruction word |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| acc_clear | input | 1 | Synchronous accumulator clear |
| acc_out | output | 40 | Accumulator value |
| undef_out | output | 1 | One-cycle undefined-instruction pulse |

## Verification
Some properties are checked by assertions on every cycle:

- the accumulator holds its value after an undefined word and while no instruction is issued;
- a clear always yields zero in the following cycle;
- an undefined pulse is only ever preceded by an issue;
- the selected-halfword addend stays inside the signed 32-bit range.

The arithmetic can only be shown by the bench's scenarios against an independent model. Those scenarios cover the signed full product with truncation and wrap, the pairing of the two halves in the dual form, the four half-select combinations, the rejection of each malformed field, and the clear that overrides an issue in the same cycle.

// File: rtl/pmac_pkg.sv
package pmac_pkg;
    localparam int DATA_W = 32;
    localparam int HALF_W = DATA_W / 2;
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = 40;
    localparam int INSTR_W = 32;
    localparam int OP_LO  = 18;
    localparam int SEL_LO = 16;
    localparam int TAG_LO = 4;
    localparam int TAG_W  = 8;
    localparam logic [TAG_W-1:0] TAG_MAC = 8'h01;
    localparam int LANES  = 2;

    typedef enum logic [1:0] {
        OP_FULL = 2'b00,
        OP_RSVD = 2'b01,
        OP_DUAL = 2'b10,
        OP_SEL  = 2'b11
    } op_e;

    typedef struct packed {
        logic ok;
        op_e  op;
        logic hi_a;
        logic hi_b;
    } dec_t;

    function automatic logic [ACC_W-1:0] widen_prod(input logic [DATA_W-1:0] p);
        return {{(ACC_W-DATA_W){p[DATA_W-1]}}, p};
    endfunction
endpackage

// File: rtl/pmac_decode.sv
module pmac_decode
    import pmac_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [TAG_W-1:0] tag;
    logic [1:0]       sel_bits;
    logic             tag_ok;
    logic             sel_zero;

    assign tag      = instr[TAG_LO +: TAG_W];
    assign sel_bits = instr[SEL_LO +: 2];
    assign tag_ok   = (tag == TAG_MAC);
    assign sel_zero = (sel_bits == 2'b00);

    always_comb begin
        dec.op   = op_e'(instr[OP_LO +: 2]);
        dec.hi_a = sel_bits[1];
        dec.hi_b = sel_bits[0];
        unique case (dec.op)
            OP_FULL, OP_DUAL: dec.ok = tag_ok && sel_zero;
            OP_SEL:           dec.ok = tag_ok;
            default:          dec.ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmac_addend.sv
module pmac_addend
    import pmac_pkg::*;
(
    input  dec_t              dec,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [ACC_W-1:0]  addend
);
    logic signed [PROD_W-1:0] full_prod;
    logic [DATA_W-1:0]        lane_prod [LANES];
    logic [ACC_W-1:0]         lane_ext  [LANES];

    assign full_prod = $signed(opa) * $signed(opb);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0] la;
        logic signed [HALF_W-1:0] lb;
        logic signed [DATA_W-1:0] lp;
        always_comb begin
            if (dec.op == OP_SEL) begin
                if (g == 0) begin
                    la = dec.hi_a ? opa[HALF_W +: HALF_W] : opa[0 +: HALF_W];
                    lb = dec.hi_b ? opb[HALF_W +: HALF_W] : opb[0 +: HALF_W];
                end else begin
                    la = '0;
                    lb = '0;
                end
            end else begin
                la = opa[g*HALF_W +: HALF_W];
                lb = opb[g*HALF_W +: HALF_W];
            end
        end
        assign lp           = la * lb;
        assign lane_prod[g] = lp;
        assign lane_ext[g]  = widen_prod(lane_prod[g]);
    end

    always_comb begin
        unique case (dec.op)
            OP_FULL: addend = full_prod[ACC_W-1:0];
            OP_DUAL: addend = lane_ext[0] + lane_ext[1];
            OP_SEL:  addend = lane_ext[0];
            default: addend = '0;
        endcase
    end
endmodule

// File: rtl/pmac_accum.sv
module pmac_accum
    import pmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             en,
    input  logic [ACC_W-1:0] addend,
    output logic [ACC_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (en)      acc <= acc + addend;
    end

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clear |=> (acc == '0));
endmodule

// File: rtl/pmac_unit.sv
module pmac_unit
    import pmac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    output logic                issue_ready,
    input  logic [INSTR_W-1:0]  instr,
    input  logic [DATA_W-1:0]   opa,
    input  logic [DATA_W-1:0]   opb,
    input  logic                acc_clear,
    output logic [ACC_W-1:0]    acc_out,
    output logic                undef_out
);
    dec_t             dec;
    logic [ACC_W-1:0] addend;
    logic             fire;

    assign issue_ready = !rst;
    assign fire        = issue_valid && issue_ready;

    pmac_decode u_dec (.instr(instr), .dec(dec));

    pmac_addend u_add (.dec(dec), .opa(opa), .opb(opb), .addend(addend));

    pmac_accum u_acc (
        .clk(clk), .rst(rst), .clear(acc_clear),
        .en(fire && dec.ok), .addend(addend), .acc(acc_out)
    );

    always_ff @(posedge clk) begin
        if (rst) undef_out <= 1'b0;
        else     undef_out <= fire && !dec.ok;
    end

    a_r7_undef_holds_acc: assert property (@(posedge clk) disable iff (rst)
        (fire && !dec.ok && !acc_clear) |=> $stable(acc_out));

    a_r7_undef_cause: assert property (@(posedge clk) disable iff (rst)
        undef_out |-> $past(issue_valid));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!issue_valid && !acc_clear) |=> ($stable(acc_out) && !undef_out));

    a_r6_sel_range: assert property (@(posedge clk) disable iff (rst)
        (fire && dec.ok && dec.op == OP_SEL) |->
        ((addend[ACC_W-1:DATA_W-1] == '0) || (addend[ACC_W-1:DATA_W-1] == '1)));
endmodule

// File: tb/pmac_unit_test.sv
`timescale 1ns/1ps
module pmac_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_valid;
    logic        issue_ready;
    logic [31:0] instr, opa, opb;
    logic        acc_clear;
    logic [39:0] acc_out;
    logic        undef_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [39:0] exp_acc_q [$];
    logic        exp_und_q [$];
    string       exp_tag_q [$];
    logic [39:0] model = '0;

    always #2 clk = ~clk;

    pmac_unit uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_ready(issue_ready),
        .instr(instr), .opa(opa), .opb(opb), .acc_clear(acc_clear),
        .acc_out(acc_out), .undef_out(undef_out)
    );

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [1:0] xy,
                                       input logic [7:0] tag, input logic [11:0] hi = 12'hEE0,
                                       input logic [3:0] mid = 4'h0, input logic [3:0] lo = 4'h0);
        return {hi, op, xy, mid, tag, lo};
    endfunction

    function automatic logic [39:0] h16(input logic [15:0] a, input logic [15:0] b);
        longint p = longint'($signed(a)) * longint'($signed(b));
        return p[39:0];
    endfunction

    task automatic check(input string tag, input logic [39:0] got, input logic [39:0] want);
        total++;
        if (got !== want) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, want);
        end
    endtask

    // Monitor: compares one expected item per cycle after a driven edge
    always @(negedge clk) begin
        if (exp_acc_q.size() > 0) begin
            logic [39:0] ea;
            logic        eu;
            string       et;
            ea = exp_acc_q.pop_front();
            eu = exp_und_q.pop_front();
            et = exp_tag_q.pop_front();
            check({et, " acc"}, acc_out, ea);
            check({et, " undef"}, {39'd0, undef_out}, {39'd0, eu});
        end
    end

    // Driver: one cycle, model update, push expectation
    task automatic drive(input string tag, input logic v, input logic [31:0] ins,
                         input logic [31:0] a, input logic [31:0] b, input logic clr);
        logic        legal;
        logic [39:0] add;
        longint      pf;
        @(negedge clk);
        issue_valid = v; instr = ins; opa = a; opb = b; acc_clear = clr;
        legal = (ins[11:4] == 8'h01);
        add = '0;
        case (ins[19:18])
            2'b00: begin
                legal = legal && ins[17:16] == 2'b00;
                pf = longint'($signed(a)) * longint'($signed(b));
                add = pf[39:0];
            end
            2'b10: begin
                legal = legal && ins[17:16] == 2'b00;
                add = h16(a[31:16], b[31:16]) + h16(a[15:0], b[15:0]);
            end
            2'b11: add = h16(ins[17] ? a[31:16] : a[15:0], ins[16] ? b[31:16] : b[15:0]);
            default: legal = 1'b0;
        endcase
        if (clr)             model = '0;
        else if (v && legal) model = model + add;
        @(posedge clk);
        #1;
        exp_acc_q.push_back(model);
        exp_und_q.push_back(v && !legal);
        exp_tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1; issue_valid = 0; instr = '0; opa = '0; opb = '0; acc_clear = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 acc reset", acc_out, 40'd0);
        check("R10 undef reset", {39'd0, undef_out}, 40'd0);
        check("R10 ready in reset", {39'd0, issue_ready}, 40'd0);
        rst = 0;
        @(negedge clk);
        check("R10 ready after reset", {39'd0, issue_ready}, 40'd1);

        // R1 R4 full-word signed
        drive("R4 full pos",   1, mk(2'b00, 2'b00, 8'h01), 32'd1000, 32'd3000, 0);
        drive("R4 full neg",   1, mk(2'b00, 2'b00, 8'h01), 32'hFFFF_FFF6, 32'd7, 0);
        drive("R4 full big",   1, mk(2'b00, 2'b00, 8'h01), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
        drive("R4 full minsq", 1, mk(2'b00, 2'b00, 8'h01), 32'h8000_0000, 32'h8000_0000, 0);
        drive("R9 clear",      0, '0, '0, '0, 1);
        // R5 dual-halfword
        drive("R5 dual",       1, mk(2'b10, 2'b00, 8'h01), 32'h0003_FFFE, 32'hFFFB_0005, 0);
        drive("R5 dual max",   1, mk(2'b10, 2'b00, 8'h01), 32'h8000_8000, 32'h8000_8000, 0);
        // R6 selectable halves, all four
        for (int s = 0; s < 4; s++)
            drive($sformatf("R6 sel xy=%0d", s), 1, mk(2'b11, 2'(s), 8'h01),
                  32'h0007_FFFD, 32'hFFF0_0009, 0);
        drive("R3 sel xy ok",  1, mk(2'b11, 2'b11, 8'h01), 32'hFFFF_1234, 32'h8000_0002, 0);
        // R1 R2 R3 R7 rejects
        drive("R1 rsvd op",    1, mk(2'b01, 2'b00, 8'h01), 32'd5, 32'd5, 0);
        drive("R2 tag 02",     1, mk(2'b00, 2'b00, 8'h02), 32'd5, 32'd5, 0);
        drive("R2 tag 00",     1, mk(2'b11, 2'b00, 8'h00), 32'd5, 32'd5, 0);
        drive("R2 tag 81",     1, mk(2'b10, 2'b00, 8'h81), 32'd5, 32'd5, 0);
        drive("R3 full xy",    1, mk(2'b00, 2'b10, 8'h01), 32'd5, 32'd5, 0);
        drive("R3 dual xy",    1, mk(2'b10, 2'b01, 8'h01), 32'd5, 32'd5, 0);
        drive("R7 undef drop", 0, '0, '0, '0, 0);
        // R11 idle and ignored fields
        drive("R11 idle",      0, mk(2'b00, 2'b00, 8'h01), 32'd99, 32'd99, 0);
        drive("R11 other bits", 1, mk(2'b00, 2'b00, 8'h01, 12'h123, 4'hA, 4'h5), 32'd11, 32'd13, 0);
        // R8 back-to-back accumulation
        for (int k = 0; k < 6; k++)
            drive("R8 b2b", 1, mk(2'b10, 2'b00, 8'h01), 32'(k * 70001), 32'hFFFF_0003, 0);
        // R4 wrap past 2^40
        for (int k = 0; k < 4; k++)
            drive("R4 wrap", 1, mk(2'b00, 2'b00, 8'h01), 32'h7FFF_FFFF, 32'h0000_4000, 0);
        // R9 clear wins over same-cycle issue
        drive("R9 clear prio", 1, mk(2'b00, 2'b00, 8'h01), 32'd12, 32'd12, 1);
        drive("R8 after clear", 1, mk(2'b11, 2'b10, 8'h01), 32'hFFFE_0000, 32'h0000_0003, 0);
        drive("R7 undef after", 1, mk(2'b01, 2'b11, 8'h01), 32'd1, 32'd1, 0);
        drive("R11 tail idle", 0, '0, '0, '0, 0);
        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule